// File: doc/BRIEF.md
# Dual-mode CAN interrupt controller

This block carries the status and interrupt bookkeeping of a CAN controller whose register set works in one of two modes, extended or basic. It takes write strobes for its command, interrupt-enable, control and clock-divider registers, and a read strobe for the interrupt-flag register. It also takes single-cycle event pulses from the protocol engine: start of reception, frame received, receive overrun and transmit complete. From these it keeps two separate banks of status and flag bits, one for each mode. It drives a single level interrupt line.

The mode comes from the top bit of the clock-divider register. Only the bank of the active mode reacts to events, commands and reads. The interrupt line is always a function of the active bank's flags and of that mode's enable source. In extended mode the enable source is the interrupt-enable register. In basic mode it is the control register, shifted right by one place. A small saturating counter stands in for the receive message store. It counts frames in and release commands out, and the receive flag follows it.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset both banks' flags and status are 0, all enables are 0, the counter is 0, basic mode is selected and `irq` is low.
- R2: `ext_mode` equals bit 7 of the last value written to the clock-divider register. Its other bits have no effect on the mode.
- R3: In extended mode `irq` is high exactly when (interrupt-enable register AND active flags) is nonzero.
- R4: In basic mode `irq` is high exactly when ((control >> 1) AND active flags) is nonzero. So control bit 1 enables receive, bit 2 enables transmit and bit 4 enables overrun.
- R5: Flag bits are: 0 receive, 1 transmit, 3 overrun. Status bits are: 0 receive buffer full, 1 overrun, 4 receiving, 5 transmitting. A command write with bit 0 set sets status bit 5. A `tx_done` pulse clears status bit 5 and sets flag bit 1.
- R6: `rx_sof` sets status bit 4. `rx_frame` sets status bit 0 and flag bit 0, clears status bit 4, and increments `msg_pending`, which saturates at 2^CNT_W-1.
- R7: `rx_overrun` sets status bit 1 and flag bit 3 and clears status bit 4. It leaves `msg_pending` unchanged.
- R8: A command write with bit 2 set decrements a nonzero `msg_pending`. When the count is then 0, it clears status bit 0 and flag bit 0. At a count of 0 it changes nothing.
- R9: A command write with bit 3 set clears status bit 1 and flag bit 3.
- R10: While `flag_rd` is high, `flag_rdata` shows the active flags. After the read all active flags are 0, except flag bit 0, which is 1 if `msg_pending` is nonzero after that cycle.
- R11: An event that arrives in the same cycle as a read-clear wins: its flag is set after the cycle.
- R12: Events, commands and reads change only the bank of the active mode. The other bank keeps its contents and shows them again after a mode switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Write strobe, interrupt-enable register |
| ctl_wr | input | 1 | Write strobe, control register |
| cdr_wr | input | 1 | Write strobe, clock-divider register |
| cmd_wr | input | 1 | Write strobe, command register |
| wr_data | input | 8 | Write data shared by all write strobes |
| flag_rd | input | 1 | Read strobe, interrupt-flag register (clears on read) |
| tx_done | input | 1 | Transmission completed pulse |
| rx_sof | input | 1 | Reception started pulse |
| rx_frame | input | 1 | Good frame received pulse |
| rx_overrun | input | 1 | Receive overrun pulse |
| flag_rdata | output | 8 | Active-mode interrupt flags |
| status | output | 8 | Active-mode status bits |
| ext_mode | output | 1 | 1 = extended mode, 0 = basic mode |
| msg_pending | output | CNT_W | Pending receive message count |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case is a bank that changes while it is hidden. The bench first leaves overrun and transmit state in the basic bank. It then switches to extended mode, raises and masks a transmit interrupt there, and switches back. The basic flags, status and interrupt level must come back unchanged. A read-clear in the same cycle as a received frame is driven directly, and the read data is sampled before the clock edge. The counter is also filled past its limit to check saturation.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int FLG_RX  = 0;
    localparam int FLG_TX  = 1;
    localparam int FLG_OVR = 3;

    localparam int ST_RXFULL = 0;
    localparam int ST_OVR    = 1;
    localparam int ST_RXACT  = 4;
    localparam int ST_TXACT  = 5;

    localparam int CMD_TXREQ   = 0;
    localparam int CMD_RELEASE = 2;
    localparam int CMD_CLROVR  = 3;

    localparam int MODE_BIT = 7;

    typedef struct packed {
        logic tx_req;
        logic release_msg;
        logic clr_ovr;
    } cmd_t;

    typedef struct packed {
        logic sof;
        logic frame;
        logic ovr;
        logic txd;
    } evt_t;

    function automatic cmd_t decode_cmd(input logic wr, input logic [7:0] d);
        cmd_t c;
        c.tx_req      = wr & d[CMD_TXREQ];
        c.release_msg = wr & d[CMD_RELEASE];
        c.clr_ovr     = wr & d[CMD_CLROVR];
        return c;
    endfunction

    function automatic logic irq_level(input logic ext, input logic [7:0] flg,
                                       input logic [7:0] ier, input logic [7:0] ctl);
        logic [7:0] en;
        en = ext ? ier : (ctl >> 1);
        return |(en & flg);
    endfunction

endpackage

// File: rtl/can_irq_cfg.sv
module can_irq_cfg (
    input  logic       clk,
    input  logic       rst,
    input  logic       ier_wr,
    input  logic       ctl_wr,
    input  logic       cdr_wr,
    input  logic [7:0] wr_data,
    output logic [7:0] ier_q,
    output logic [7:0] ctl_q,
    output logic       ext_q
);
    import can_irq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q <= '0;
            ctl_q <= '0;
            ext_q <= 1'b0;
        end else begin
            if (ier_wr) ier_q <= wr_data;
            if (ctl_wr) ctl_q <= wr_data;
            if (cdr_wr) ext_q <= wr_data[MODE_BIT];
        end
    end
endmodule

// File: rtl/can_irq_msg_cnt.sv
module can_irq_msg_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             release_msg,
    input  logic             frame,
    output logic [CNT_W-1:0] cnt_q,
    output logic             nz_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] after_dec;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        after_dec = (release_msg && cnt_q != '0) ? cnt_q - ONE : cnt_q;
        cnt_d     = (frame && after_dec != CNT_MAX) ? after_dec + ONE : after_dec;
        nz_next   = (cnt_d != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/can_irq_flag_bank.sv
module can_irq_flag_bank (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                rd_clr,
    input  can_irq_pkg::cmd_t   cmd,
    input  can_irq_pkg::evt_t   evt,
    input  logic                msgs_left,
    output logic [7:0]          flags_q,
    output logic [7:0]          stat_q
);
    import can_irq_pkg::*;

    logic [7:0] f_d;
    logic [7:0] s_d;

    // Order: read-clear, then commands, then engine events (events win).
    always_comb begin
        f_d = flags_q;
        s_d = stat_q;
        if (sel) begin
            if (rd_clr) begin
                f_d         = '0;
                f_d[FLG_RX] = msgs_left;
            end
            if (cmd.tx_req) s_d[ST_TXACT] = 1'b1;
            if (cmd.release_msg && !msgs_left) begin
                s_d[ST_RXFULL] = 1'b0;
                f_d[FLG_RX]    = 1'b0;
            end
            if (cmd.clr_ovr) begin
                s_d[ST_OVR]  = 1'b0;
                f_d[FLG_OVR] = 1'b0;
            end
            if (evt.sof) s_d[ST_RXACT] = 1'b1;
            if (evt.txd) begin
                s_d[ST_TXACT] = 1'b0;
                f_d[FLG_TX]   = 1'b1;
            end
            if (evt.ovr) begin
                s_d[ST_OVR]   = 1'b1;
                s_d[ST_RXACT] = 1'b0;
                f_d[FLG_OVR]  = 1'b1;
            end
            if (evt.frame) begin
                s_d[ST_RXFULL] = 1'b1;
                s_d[ST_RXACT]  = 1'b0;
                f_d[FLG_RX]    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            stat_q  <= '0;
        end else begin
            flags_q <= f_d;
            stat_q  <= s_d;
        end
    end
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ier_wr,
    input  logic             ctl_wr,
    input  logic             cdr_wr,
    input  logic             cmd_wr,
    input  logic [7:0]       wr_data,
    input  logic             flag_rd,
    input  logic             tx_done,
    input  logic             rx_sof,
    input  logic             rx_frame,
    input  logic             rx_overrun,
    output logic [7:0]       flag_rdata,
    output logic [7:0]       status,
    output logic             ext_mode,
    output logic [CNT_W-1:0] msg_pending,
    output logic             irq
);
    import can_irq_pkg::*;

    localparam int NBANK = 2;

    logic [7:0] ier_q;
    logic [7:0] ctl_q;
    logic       msgs_left;
    cmd_t       cmd;
    evt_t       evt;
    logic [7:0] bank_flags [NBANK];
    logic [7:0] bank_stat  [NBANK];

    assign cmd = decode_cmd(cmd_wr, wr_data);
    assign evt = '{sof: rx_sof, frame: rx_frame, ovr: rx_overrun, txd: tx_done};

    can_irq_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .ier_wr  (ier_wr),
        .ctl_wr  (ctl_wr),
        .cdr_wr  (cdr_wr),
        .wr_data (wr_data),
        .ier_q   (ier_q),
        .ctl_q   (ctl_q),
        .ext_q   (ext_mode)
    );

    can_irq_msg_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .release_msg (cmd.release_msg),
        .frame       (rx_frame),
        .cnt_q       (msg_pending),
        .nz_next     (msgs_left)
    );

    // Bank 0 serves basic mode, bank 1 extended mode.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        can_irq_flag_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .sel       (ext_mode == (g == 1)),
            .rd_clr    (flag_rd),
            .cmd       (cmd),
            .evt       (evt),
            .msgs_left (msgs_left),
            .flags_q   (bank_flags[g]),
            .stat_q    (bank_stat[g])
        );
    end

    always_comb begin
        flag_rdata = ext_mode ? bank_flags[1] : bank_flags[0];
        status     = ext_mode ? bank_stat[1]  : bank_stat[0];
        irq        = irq_level(ext_mode, flag_rdata, ier_q, ctl_q);
    end
endmodule

// File: rtl/can_irq_ctrl_chk.sv
module can_irq_ctrl_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ier_wr,
    input logic             cdr_wr,
    input logic             cmd_wr,
    input logic [7:0]       wr_data,
    input logic             flag_rd,
    input logic             tx_done,
    input logic             rx_sof,
    input logic             rx_frame,
    input logic             rx_overrun,
    input logic [7:0]       flag_rdata,
    input logic [7:0]       status,
    input logic             ext_mode,
    input logic [CNT_W-1:0] msg_pending,
    input logic             irq
);
    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (!irq && flag_rdata == 8'h00 && status == 8'h00 && !ext_mode && msg_pending == '0));

    // R2
    mode_follows_cdr_chk: assert property (@(posedge clk) disable iff (rst)
        cdr_wr |=> ext_mode == $past(wr_data[7]));

    // R3
    ext_mask_all_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && ier_wr && wr_data == 8'h00 && !cdr_wr) |=> !irq);

    // R5
    tx_event_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !cdr_wr && !cmd_wr) |=> (flag_rdata[1] && !status[5]));

    // R6
    rx_event_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_frame && !cdr_wr && !cmd_wr) |=> (flag_rdata[0] && status[0] && !status[4] && msg_pending != '0));

    // R7
    ovr_event_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !rx_frame && !cdr_wr && !cmd_wr) |=> (flag_rdata[3] && status[1] && !status[4] && $stable(msg_pending)));

    // R8
    release_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wr_data[2] && msg_pending == '0 && !rx_frame) |=> msg_pending == '0);

    // R9
    clr_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wr_data[3] && !rx_overrun && !cdr_wr) |=> (!flag_rdata[3] && !status[1]));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && msg_pending == '0 && !tx_done && !rx_frame && !rx_overrun && !cdr_wr && !cmd_wr)
        |=> flag_rdata == 8'h00);
endmodule

bind can_irq_ctrl can_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/can_irq_ctrl_bench.sv
`timescale 1ns/1ps
module can_irq_ctrl_bench;
    localparam int CNT_W = 4;

    localparam logic [3:0] OP_IER = 4'd0, OP_CTL = 4'd1, OP_CDR = 4'd2, OP_CMD = 4'd3,
                           OP_RD  = 4'd4, OP_TX  = 4'd5, OP_RX  = 4'd6, OP_OVR = 4'd7,
                           OP_SOF = 4'd8;

    // {op, data, exp flags, exp status, exp irq, exp count, requirement}
    localparam int NV = 23;
    localparam logic [36:0] VEC [0:NV-1] = '{
        {OP_CTL, 8'h02, 8'h00, 8'h00, 1'b0, 4'd0, 4'd4},  // R4
        {OP_RX,  8'h00, 8'h01, 8'h01, 1'b1, 4'd1, 4'd6},  // R6
        {OP_RX,  8'h00, 8'h01, 8'h01, 1'b1, 4'd2, 4'd6},  // R6
        {OP_RD,  8'h00, 8'h01, 8'h01, 1'b1, 4'd2, 4'd10}, // R10
        {OP_CMD, 8'h04, 8'h01, 8'h01, 1'b1, 4'd1, 4'd8},  // R8
        {OP_CMD, 8'h04, 8'h00, 8'h00, 1'b0, 4'd0, 4'd8},  // R8
        {OP_CMD, 8'h04, 8'h00, 8'h00, 1'b0, 4'd0, 4'd8},  // R8 at zero
        {OP_TX,  8'h00, 8'h02, 8'h00, 1'b0, 4'd0, 4'd5},  // R5
        {OP_CTL, 8'h04, 8'h02, 8'h00, 1'b1, 4'd0, 4'd4},  // R4
        {OP_OVR, 8'h00, 8'h0A, 8'h02, 1'b1, 4'd0, 4'd7},  // R7
        {OP_CTL, 8'h10, 8'h0A, 8'h02, 1'b1, 4'd0, 4'd4},  // R4
        {OP_CMD, 8'h08, 8'h02, 8'h00, 1'b0, 4'd0, 4'd9},  // R9
        {OP_RD,  8'h00, 8'h00, 8'h00, 1'b0, 4'd0, 4'd10}, // R10
        {OP_SOF, 8'h00, 8'h00, 8'h10, 1'b0, 4'd0, 4'd6},  // R6
        {OP_OVR, 8'h00, 8'h08, 8'h02, 1'b1, 4'd0, 4'd7},  // R7
        {OP_CMD, 8'h01, 8'h08, 8'h22, 1'b1, 4'd0, 4'd5},  // R5
        {OP_CDR, 8'h80, 8'h00, 8'h00, 1'b0, 4'd0, 4'd2},  // R2
        {OP_IER, 8'h02, 8'h00, 8'h00, 1'b0, 4'd0, 4'd3},  // R3
        {OP_TX,  8'h00, 8'h02, 8'h00, 1'b1, 4'd0, 4'd3},  // R3
        {OP_IER, 8'h01, 8'h02, 8'h00, 1'b0, 4'd0, 4'd3},  // R3
        {OP_CDR, 8'h00, 8'h08, 8'h22, 1'b1, 4'd0, 4'd12}, // R12
        {OP_CMD, 8'h08, 8'h00, 8'h20, 1'b0, 4'd0, 4'd9},  // R9
        {OP_TX,  8'h00, 8'h02, 8'h00, 1'b0, 4'd0, 4'd5}   // R5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ier_wr = 0, ctl_wr = 0, cdr_wr = 0, cmd_wr = 0, flag_rd = 0;
    logic tx_done = 0, rx_sof = 0, rx_frame = 0, rx_overrun = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] flag_rdata, status;
    logic ext_mode, irq;
    logic [CNT_W-1:0] msg_pending;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    can_irq_ctrl #(.CNT_W(CNT_W)) u_can_irq_ctrl (.*);

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] d);
        wr_data    = d;
        ier_wr     = (op == OP_IER);
        ctl_wr     = (op == OP_CTL);
        cdr_wr     = (op == OP_CDR);
        cmd_wr     = (op == OP_CMD);
        flag_rd    = (op == OP_RD);
        tx_done    = (op == OP_TX);
        rx_frame   = (op == OP_RX);
        rx_overrun = (op == OP_OVR);
        rx_sof     = (op == OP_SOF);
    endtask

    task automatic idle();
        drive(4'hF, 8'h00);
    endtask

    task automatic step(input logic [3:0] op, input logic [7:0] d);
        @(negedge clk);
        drive(op, d);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "flags", flag_rdata, 0);
        check("R1", "status", status, 0);
        check("R1", "irq", irq, 0);
        check("R1", "mode", ext_mode, 0);
        check("R1", "count", msg_pending, 0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            step(VEC[i][36:33], VEC[i][32:25]);
            rq = $sformatf("R%0d", VEC[i][3:0]);
            check(rq, $sformatf("vec%0d flags", i), flag_rdata, VEC[i][24:17]);
            check(rq, $sformatf("vec%0d status", i), status, VEC[i][16:9]);
            check(rq, $sformatf("vec%0d irq", i), irq, VEC[i][8]);
            check(rq, $sformatf("vec%0d count", i), msg_pending, VEC[i][7:4]);
        end

        // R10 + R11: read-clear with frame in same cycle; read data shows old flags
        @(negedge clk);
        drive(OP_RD, 8'h00);
        rx_frame = 1'b1;
        #1;
        check("R10", "read data before edge", flag_rdata, 8'h02);
        @(negedge clk);
        idle();
        check("R11", "flags after read+frame", flag_rdata, 8'h01);
        check("R11", "count after read+frame", msg_pending, 1);

        // R2: bits other than 7 do not select extended mode
        step(OP_CDR, 8'h7F);
        check("R2", "mode with 0x7F", ext_mode, 0);

        // R3: extended overrun enable
        step(OP_CDR, 8'hFF);
        check("R2", "mode with 0xFF", ext_mode, 1);
        step(OP_IER, 8'h08);
        step(OP_OVR, 8'h00);
        check("R3", "ext ovr irq", irq, 1);
        check("R7", "count held on overrun", msg_pending, 1);
        step(OP_IER, 8'h00);
        check("R3", "ext masked irq", irq, 0);

        // R6: counter saturates at 2^CNT_W-1
        for (int k = 0; k < 20; k++) step(OP_RX, 8'h00);
        check("R6", "count saturates", msg_pending, 15);

        // R10: read with messages left keeps receive flag only
        step(OP_RD, 8'h00);
        check("R10", "flags after read, msgs left", flag_rdata, 8'h01);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "flags after reset", flag_rdata, 0);
        check("R1", "mode after reset", ext_mode, 0);
        check("R1", "count after reset", msg_pending, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule